// File: doc/BRIEF.md
# Priority Interrupt Controller with Command-Word Status and Poll Logic

This block is an eight-level priority interrupt controller core. Rising edges on the request lines are latched into a request register. A set of in-service bits records which levels are being handled, and an eight-bit mask removes levels from arbitration. A fixed-priority resolver, with level 0 highest, picks the winning level. The resolver drives an interrupt output whenever some level is eligible.

A byte-wide register port has two addresses:
- **Address 0** takes command writes and returns the selected status register on reads.
- **Address 1** writes and reads the mask.

A command write does three things: it chooses which status register a plain read returns, it can arm a one-shot poll that turns the next address-0 read into an acknowledge, and it can switch special mask mode on or off when its enable bit is set. A separate acknowledge strobe grants the winning level. An end-of-interrupt strobe retires the highest-priority level that is in service. A synchronous initialization pulse brings the command state back to its starting point.

The read path is a four-state machine. The states are ST_SHOW_REQ (plain reads return requests), ST_SHOW_SVC (plain reads return in-service bits), ST_POLL_REQ and ST_POLL_SVC (a poll is armed, and the selection that follows the poll is remembered). There are four transitions:
- **select**: a command with bit 1 set changes the remembered selection.
- **arm**: a command with bit 2 set enters a poll state.
- **consume**: an address-0 read in a poll state returns to the matching show state.
- **init**: the initialization pulse forces ST_SHOW_REQ.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are 00h, special mask mode is off, no poll is armed, read data is 00h and address-0 reads return the request register.
- R2: A write to address 0 is a command only when data bits 4:3 equal 01 and bit 7 is 0. Any other address-0 write changes no selection, poll or mode state.
- R3: In a command, bits 1:0 = 10 select the request register and 11 select the in-service register for address-0 reads. Values 00 and 01 keep the current selection. The selection persists over any number of reads.
- R4: A read takes effect at the clock edge where rd_i is high, and rdata_o shows the value from then until the next read. An address-1 read returns the mask, and an address-1 write loads the mask.
- R5: A command with bit 2 set arms a poll. The next address-0 read returns bit 7 = 1 with the winning level in bits 2:0 (bits 6:3 zero), or 00h when no level is eligible. The poll then disarms.
- R6: A poll read that finds an eligible level sets that level's in-service bit and clears its request bit.
- R7: Command bit 6 sets or clears special mask mode only when bit 5 is set. With bit 5 clear, the mode is held.
- R8: A level is eligible when it is requested and unmasked. Outside special mask mode it must also have no in-service bit at its own or any lower index. In special mask mode only its own in-service bit blocks it. The lowest eligible index wins.
- R9: A request bit is set by a 0-to-1 edge of its line. It stays set while the line is held, until the level is acknowledged.
- R10: int_o is high exactly when some level is eligible. ack_i acknowledges the winning level in the same way as a poll read.
- R11: eoi_i clears the lowest-index set in-service bit.
- R12: init_i clears the in-service bits, the mask, special mask mode and any armed poll, and restores the request-register selection. Latched requests are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous initialization pulse |
| irq_i | input | NUM_LVL | Request lines, edge sensitive |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = command/status, 1 = mask |
| wdata_i | input | 8 | Write data |
| ack_i | input | 1 | Acknowledge strobe for the winning level |
| eoi_i | input | 1 | End-of-interrupt strobe |
| int_o | output | 1 | Some level is eligible |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with the default NUM_LVL of 8. With that value every bit of the mask, request and in-service bytes is in play, and the full three-bit level field of the poll byte can take each of its values, including the top level 7. A reference model in the bench follows the requirements, and random command bytes are mostly valid with reserved and non-command patterns mixed in. This drives the select, arm, consume and init transitions in every order, and covers special mask mode against stacked in-service levels.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_SHOW_REQ = 2'b00,
        ST_SHOW_SVC = 2'b01,
        ST_POLL_REQ = 2'b10,
        ST_POLL_SVC = 2'b11
    } rd_state_e;

    function automatic rd_state_e mk_state(input logic poll, input logic svc);
        return rd_state_e'({poll, svc});
    endfunction

endpackage

// File: rtl/irqc_cmd_fsm.sv
module irqc_cmd_fsm
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic              port_rd_i,
    output logic              sel_svc_o,
    output logic              poll_armed_o,
    output logic              smm_o
);

    rd_state_e state_q, state_d;
    logic      smm_q;
    logic      is_cmd, arm, sel_d;

    assign is_cmd = wr_i && (cmd_i[4:3] == 2'b01) && !cmd_i[7];
    assign arm    = is_cmd && cmd_i[2];
    assign sel_d  = (is_cmd && cmd_i[1]) ? cmd_i[0] : sel_svc_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHOW_REQ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHOW_REQ, ST_SHOW_SVC: state_d = mk_state(arm, sel_d);
            ST_POLL_REQ, ST_POLL_SVC: begin
                if (arm)            state_d = mk_state(1'b1, sel_d);
                else if (port_rd_i) state_d = mk_state(1'b0, sel_d);
                else                state_d = mk_state(1'b1, sel_d);
            end
        endcase
        if (init_i) state_d = ST_SHOW_REQ;
    end

    always_comb begin
        sel_svc_o    = 1'b0;
        poll_armed_o = 1'b0;
        unique case (state_q)
            ST_SHOW_REQ: begin sel_svc_o = 1'b0; poll_armed_o = 1'b0; end
            ST_SHOW_SVC: begin sel_svc_o = 1'b1; poll_armed_o = 1'b0; end
            ST_POLL_REQ: begin sel_svc_o = 1'b0; poll_armed_o = 1'b1; end
            ST_POLL_SVC: begin sel_svc_o = 1'b1; poll_armed_o = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  smm_q <= 1'b0;
        else if (init_i)             smm_q <= 1'b0;
        else if (is_cmd && cmd_i[5]) smm_q <= cmd_i[6];
    end

    assign smm_o = smm_q;

    AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!(is_cmd && cmd_i[1]) && !init_i) |=> (sel_svc_o == $past(sel_svc_o))); // R3

    AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_i && poll_armed_o && !arm && !init_i) |=> !poll_armed_o); // R5

    AST_SMM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && cmd_i[5] && cmd_i[4:3] == 2'b01 && !cmd_i[7]) && !init_i) |=> $stable(smm_q)); // R7

    AST_BADCMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (cmd_i[7] || cmd_i[4:3] != 2'b01) && !port_rd_i && !init_i)
        |=> ($stable(state_q) && $stable(smm_q))); // R2

    AST_INIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (state_q == ST_SHOW_REQ && !smm_q)); // R12

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_LVL = 8,
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic [NUM_LVL-1:0] req_i,
    input  logic [NUM_LVL-1:0] isr_i,
    input  logic [NUM_LVL-1:0] mask_i,
    input  logic               smm_i,
    output logic [NUM_LVL-1:0] grant_o,
    output logic               any_o,
    output logic [LVL_W-1:0]   lvl_o
);

    logic [NUM_LVL-1:0] elig;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic blk;
        assign blk     = smm_i ? isr_i[g] : (|isr_i[g:0]);
        assign elig[g] = req_i[g] & ~mask_i[g] & ~blk;
    end

    assign grant_o = elig & (~elig + NUM_LVL'(1));
    assign any_o   = |elig;

    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (grant_o[i]) lvl_o = i[LVL_W-1:0];
        end
    end

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic [NUM_LVL-1:0] irq_i,
    input  logic               mask_wr_i,
    input  logic [NUM_LVL-1:0] mask_d_i,
    input  logic               ack_i,
    input  logic [NUM_LVL-1:0] grant_i,
    input  logic               eoi_i,
    output logic [NUM_LVL-1:0] req_o,
    output logic [NUM_LVL-1:0] isr_o,
    output logic [NUM_LVL-1:0] mask_o
);

    logic [NUM_LVL-1:0] prev_q, req_q, isr_q, mask_q;
    logic [NUM_LVL-1:0] ack_bits, eoi_bits;

    assign ack_bits = ack_i ? grant_i : '0;
    assign eoi_bits = eoi_i ? (isr_q & (~isr_q + NUM_LVL'(1))) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= irq_i;
            req_q  <= (req_q & ~ack_bits) | (irq_i & ~prev_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q  <= '0;
            mask_q <= '0;
        end else if (init_i) begin
            isr_q  <= '0;
            mask_q <= '0;
        end else begin
            isr_q <= (isr_q & ~eoi_bits) | ack_bits;
            if (mask_wr_i) mask_q <= mask_d_i;
        end
    end

    assign req_o  = req_q;
    assign isr_o  = isr_q;
    assign mask_o = mask_q;

    AST_ACK_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (|grant_i) && !eoi_i && !init_i)
        |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R6

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && (|isr_q) && !ack_i && !init_i)
        |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R11

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (isr_q == '0 && mask_q == '0)); // R12

endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic [NUM_LVL-1:0] irq_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic               addr_i,
    input  logic [7:0]         wdata_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               int_o,
    output logic [7:0]         rdata_o
);

    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

    logic               port_rd, sel_svc, poll_armed, smm, poll_read, ack_do, any;
    logic [NUM_LVL-1:0] req, isr, mask, grant;
    logic [LVL_W-1:0]   lvl;
    logic [2:0]         lvl3;
    logic [7:0]         rd_mux, req8, isr8, mask8, rdata_q;

    assign port_rd   = rd_i && !addr_i;
    assign poll_read = port_rd && poll_armed;
    assign ack_do    = ack_i || poll_read;

    irqc_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .wr_i         (wr_i && !addr_i),
        .cmd_i        (wdata_i),
        .port_rd_i    (port_rd),
        .sel_svc_o    (sel_svc),
        .poll_armed_o (poll_armed),
        .smm_o        (smm)
    );

    irqc_status #(.NUM_LVL(NUM_LVL)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .irq_i     (irq_i),
        .mask_wr_i (wr_i && addr_i),
        .mask_d_i  (wdata_i[NUM_LVL-1:0]),
        .ack_i     (ack_do),
        .grant_i   (grant),
        .eoi_i     (eoi_i),
        .req_o     (req),
        .isr_o     (isr),
        .mask_o    (mask)
    );

    irqc_prio #(.NUM_LVL(NUM_LVL)) u_prio (
        .req_i   (req),
        .isr_i   (isr),
        .mask_i  (mask),
        .smm_i   (smm),
        .grant_o (grant),
        .any_o   (any),
        .lvl_o   (lvl)
    );

    always_comb begin
        lvl3  = '0;
        req8  = '0;
        isr8  = '0;
        mask8 = '0;
        lvl3[LVL_W-1:0]  = lvl;
        req8[NUM_LVL-1:0]  = req;
        isr8[NUM_LVL-1:0]  = isr;
        mask8[NUM_LVL-1:0] = mask;
        if (addr_i)          rd_mux = mask8;
        else if (poll_armed) rd_mux = any ? {1'b1, 4'b0000, lvl3} : 8'h00;
        else if (sel_svc)    rd_mux = isr8;
        else                 rd_mux = req8;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign int_o   = any;

    AST_NO_MASKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & mask) == '0); // R8

    AST_POLL_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_read && any && !init_i) |=> ((isr & $past(grant)) == $past(grant))); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o)); // R4

endmodule

// File: tb/irq_cmd_ctrl_tb.sv
module irq_cmd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
    logic          ack_i = 1'b0, eoi_i = 1'b0;
    logic [NL-1:0] irq_i = '0;
    logic [7:0]    wdata_i = '0;
    logic          int_o;
    logic [7:0]    rdata_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] m_req = '0, m_isr = '0, m_mask = '0, m_prev = '0, m_rdata = '0;
    logic       m_smm = 1'b0, m_sel = 1'b0, m_poll = 1'b0;
    logic [7:0] irq_v = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cmd_ctrl #(.NUM_LVL(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .irq_i(irq_i),
        .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .ack_i(ack_i), .eoi_i(eoi_i), .int_o(int_o), .rdata_o(rdata_o)
    );

    function automatic logic [7:0] f_elig();
        logic [7:0] e;
        for (int i = 0; i < 8; i++) begin
            logic blk;
            blk = m_smm ? m_isr[i] : (((m_isr << (7 - i)) & 8'hFF) != 0);
            e[i] = m_req[i] & ~m_mask[i] & ~blk;
        end
        return e;
    endfunction

    function automatic logic [7:0] f_lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 8'(1 << i);
        return 8'h00;
    endfunction

    function automatic logic [2:0] f_index(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negative edge; drives one cycle and checks results at the next negative edge
    task automatic step(input logic wr, input logic rd, input logic ad, input logic [7:0] wd,
                        input logic ak, input logic eo, input logic in, input string tag);
        logic [7:0] el, win, ackb, eoib;
        logic       any, prd, iscmd;
        string      t;
        chk("R10 int", {7'd0, int_o}, {7'd0, |f_elig()});
        irq_i = irq_v; wr_i = wr; rd_i = rd; addr_i = ad; wdata_i = wd;
        ack_i = ak; eoi_i = eo; init_i = in;
        el   = f_elig();
        win  = f_lowest(el);
        any  = |el;
        prd  = rd && !ad && m_poll;
        ackb = ((ak || prd) && any) ? win : 8'h00;
        eoib = eo ? f_lowest(m_isr) : 8'h00;
        iscmd = wr && !ad && (wd[4:3] == 2'b01) && !wd[7];
        t = tag;
        if (t == "") t = ad ? "R4" : (m_poll ? "R5" : (m_sel ? "R3" : "R9"));
        if (rd) begin
            if (ad)          m_rdata = m_mask;
            else if (m_poll) m_rdata = any ? {1'b1, 4'b0000, f_index(win)} : 8'h00;
            else if (m_sel)  m_rdata = m_isr;
            else             m_rdata = m_req;
        end
        m_req  = (m_req & ~ackb) | (irq_v & ~m_prev);
        m_prev = irq_v;
        if (in) begin
            m_isr = 8'h00; m_mask = 8'h00; m_smm = 1'b0; m_sel = 1'b0; m_poll = 1'b0;
        end else begin
            m_isr = (m_isr & ~eoib) | ackb;
            if (wr && ad) m_mask = wd;
            if (iscmd && wd[5]) m_smm = wd[6];
            if (iscmd && wd[1]) m_sel = wd[0];
            if (iscmd && wd[2]) m_poll = 1'b1;
            else if (prd)       m_poll = 1'b0;
        end
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0; init_i = 1'b0;
        if (rd) chk(t, rdata_o, m_rdata);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "");
    endtask
    task automatic cmd(input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, 1'b0, d, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic rd0(input string tag);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd1750);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int", {7'd0, int_o}, 8'h00);
        chk("R1 rdata", rdata_o, 8'h00);
        rd0("R1");
        chk("R1 req read", rdata_o, 8'h00);
        step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R1");

        // R9 edge latching, held line sets once
        irq_v = 8'h08; idle(); irq_v = 8'h00; idle();
        irq_v = 8'h20; idle(); idle(); idle();
        rd0("R9");
        chk("R9 literal", rdata_o, 8'h28);

        // R5 / R6 poll and its acknowledge
        cmd(8'h0C, "R5");
        rd0("R5");
        chk("R5 literal", rdata_o, 8'h83);
        rd0("R6");
        chk("R6 req cleared", rdata_o, 8'h20);
        cmd(8'h0B, "R3");
        rd0("R6");
        chk("R6 svc set", rdata_o, 8'h08);
        rd0("R3"); rd0("R3");

        // R8 fixed blocking by in-service level 3
        idle();
        chk("R8 blocked", {7'd0, int_o}, 8'h00);
        irq_v = 8'h22; idle(); irq_v = 8'h20;
        chk("R8 higher level", {7'd0, int_o}, 8'h01);
        cmd(8'h0C, "R5"); rd0("R5");
        chk("R5 level1", rdata_o, 8'h81);
        rd0("R8");

        // R11 end of interrupt retires level 1
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R11");
        cmd(8'h0B, "R11"); rd0("R11");
        chk("R11 literal", rdata_o, 8'h08);

        // R7 special mask enable handling
        irq_v = 8'h00; idle(); irq_v = 8'h20; idle();
        cmd(8'h48, "R7"); idle();
        chk("R7 held off", {7'd0, int_o}, 8'h00);
        cmd(8'h68, "R7"); idle();
        chk("R7 on", {7'd0, int_o}, 8'h01);
        cmd(8'h28, "R7"); idle();
        chk("R7 off", {7'd0, int_o}, 8'h00);

        // R2 non-command writes ignored
        cmd(8'h8A, "R2"); rd0("R2");
        cmd(8'h12, "R2"); rd0("R2");
        cmd(8'h8C, "R2"); rd0("R2");
        chk("R2 still svc", rdata_o, 8'h08);
        cmd(8'h09, "R3"); rd0("R3");

        // R4 mask access, masked level stays out
        cmd(8'h68, "R7");
        step(1'b1, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
        chk("R4 mask", rdata_o, 8'h20);
        idle();
        chk("R8 masked", {7'd0, int_o}, 8'h00);

        // R12 init keeps requests, resets selection
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R12");
        rd0("R12");
        chk("R12 req kept", rdata_o, 8'h20);
        step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R12");
        chk("R12 mask", rdata_o, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10");
        cmd(8'h0B, "R10"); rd0("R10");
        chk("R10 ack", rdata_o, 8'h20);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            logic [7:0] d;
            r = $urandom();
            irq_v = 8'($urandom());
            if (r[3:0] == 4'd0) begin
                step(1'b1, 1'b0, 1'b1, 8'($urandom()), 1'b0, 1'b0, 1'b0, "R4");
            end else if (r[3:0] < 4'd5) begin
                d = 8'($urandom());
                if (d[7:5] != 3'b111) d[7] = 1'b0;
                if (d[6:4] != 3'b111) d[4:3] = 2'b01;
                step(1'b1, r[4], r[5] & r[6], d, 1'b0, 1'b0, 1'b0, "");
            end else if (r[3:0] < 4'd10) begin
                step(1'b0, 1'b1, r[4] & r[5], 8'h00, 1'b0, 1'b0, 1'b0, "");
            end else if (r[3:0] < 4'd12) begin
                step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10");
            end else if (r[3:0] < 4'd14) begin
                step(1'b0, 1'b0, 1'b0, 8'h00, r[4], 1'b1, 1'b0, "R11");
            end else if (r[9:4] == 6'd0) begin
                step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R12");
            end else begin
                idle();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule